// File: doc/BRIEF.md
# Grouped Event Flag Combiner

This block captures single-cycle event pulses from the rest of the chip into a 128-bit flag array. Software reaches the array through a small single-cycle register port. The flag words are read-only. Flags change only when a hardware event arrives or when software writes a set word or a clear word. Each of these writes acts only on the bits written as 1.

The flag array is split into four groups of 32 positions. Each group has a mask word, where a 1 excludes that position. The block keeps, for each group, a registered combined output: the OR of that group's flags that are set and not excluded. Each combined output is also fed back as an event. When it rises, it latches into one of the four lowest flag positions, so software sees it in the flags like any other event. The remaining 124 positions are driven by the external event inputs.

Top module: `evt_flag_combiner`

## Requirements
- R1: After reset every flag is 0, every mask word is all ones and every combined output is 0.
- R2: A 1 on `sys_evt[i]` in a cycle sets flag position i+4 at the next clock edge. A write to a flag word address changes no flag.
- R3: Writing to set word w forces on every flag position 32w+b for which data bit b is 1, at the next edge. Set word addresses read as 0.
- R4: Writing to clear word w forces off every flag position 32w+b for which data bit b is 1. Bits written as 0 leave their flags unchanged. Clear word addresses read as 0.
- R5: If a hardware event and a clear write target the same flag position in the same cycle, the flag ends up set.
- R6: Mask word g can be written and read back. A 1 in bit b excludes flag position 32g+b from group g's combined output.
- R7: `comb_out[g]` is the OR of group g's set, unmasked flags, sampled at the previous clock edge. It therefore follows a flag or mask change by one cycle.
- R8: A rising edge of `comb_out[g]` sets flag position g at the next edge. While `comb_out[g]` stays high, it does not set that flag again.
- R9: `reg_addr` is a 4-bit word address. The two upper bits choose the kind: 0 for flags, 1 for set, 2 for clear, 3 for mask. The two lower bits choose the word or group index w. Flag word w holds positions 32w to 32w+31, with bit b at position 32w+b.
- R10: A flag only changes through an event, a set write or a clear write. With none of these present, the flag array holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_evt | input | 124 | Event pulses for flag positions 4 to 127 |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Single-cycle write strobe |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| comb_out | output | 4 | Registered combined output for each group |

## Verification
The in-module assertions check the following on every cycle:
- every pulse is latched;
- a clear takes effect unless an event collides with it;
- flags hold when nothing acts on them;
- each combined output matches its group's masked OR one cycle later;
- set and clear addresses read as zero.

Several behaviours only show up in the bench's scenarios:
- the three-cycle path from a mask change, through the combined output, to its feedback flag;
- the absence of a second feedback set while a combined output stays high;
- the mask readback through the address map.

A reference model driven by random event and write traffic checks every read and every output cycle.

// File: rtl/evt_flag_combiner.sv
module evt_flag_combiner #(
  parameter int GROUPS = 4,
  parameter int GRP_W  = 32,
  localparam int NUM_POS = GROUPS * GRP_W,
  localparam int EXT_W   = NUM_POS - GROUPS,
  localparam int IDX_W   = $clog2(GROUPS),
  localparam int ADDR_W  = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EXT_W-1:0]  sys_evt,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [GRP_W-1:0]  reg_wdata,
  input  logic              reg_we,
  output logic [GRP_W-1:0]  reg_rdata,
  output logic [GROUPS-1:0] comb_out
);

  localparam logic [1:0] K_FLAG = 2'd0;
  localparam logic [1:0] K_SET  = 2'd1;
  localparam logic [1:0] K_CLR  = 2'd2;
  localparam logic [1:0] K_MASK = 2'd3;

  logic [NUM_POS-1:0] flags, set_vec, clr_vec, hw_vec, flags_nxt;
  logic [GRP_W-1:0]   mask [GROUPS];
  logic [GROUPS-1:0]  grp_any, comb_q, comb_d;
  logic [1:0]         kind;
  logic [IDX_W-1:0]   idx;

  assign kind = reg_addr[ADDR_W-1 -: 2];
  assign idx  = reg_addr[IDX_W-1:0];

  assign hw_vec    = {sys_evt, comb_q & ~comb_d};
  assign flags_nxt = (flags & ~clr_vec) | set_vec | hw_vec;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign set_vec[g*GRP_W +: GRP_W] = (reg_we && kind == K_SET && idx == IDX_W'(g)) ? reg_wdata : '0;
    assign clr_vec[g*GRP_W +: GRP_W] = (reg_we && kind == K_CLR && idx == IDX_W'(g)) ? reg_wdata : '0;
    assign grp_any[g] = |(flags[g*GRP_W +: GRP_W] & ~mask[g]);

    always_ff @(posedge clk) begin
      if (!rst_n)
        mask[g] <= '1;
      else if (reg_we && kind == K_MASK && idx == IDX_W'(g))
        mask[g] <= reg_wdata;
    end

    a_r7_comb_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> comb_out[g] == $past(|(flags[g*GRP_W +: GRP_W] & ~mask[g])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags  <= '0;
      comb_q <= '0;
      comb_d <= '0;
    end else begin
      flags  <= flags_nxt;
      comb_q <= grp_any;
      comb_d <= comb_q;
    end
  end

  assign comb_out = comb_q;

  always_comb begin
    reg_rdata = '0;
    case (kind)
      K_FLAG:  reg_rdata = flags[idx*GRP_W +: GRP_W];
      K_MASK:  reg_rdata = mask[idx];
      default: reg_rdata = '0;
    endcase
  end

  a_r2_evt_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|sys_evt) |=> (flags[NUM_POS-1:GROUPS] & $past(sys_evt)) == $past(sys_evt));

  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~hw_vec)) |=> (flags & $past(clr_vec & ~hw_vec)) == '0);

  a_r5_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & hw_vec)) |=> (flags & $past(clr_vec & hw_vec)) == $past(clr_vec & hw_vec));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && hw_vec == '0) |=> $stable(flags));

  a_r3_set_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_SET || kind == K_CLR) |-> reg_rdata == '0);

endmodule

// File: tb/evt_flag_combiner_tb.sv
module evt_flag_combiner_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [123:0] sys_evt = '0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic         reg_we = 1'b0;
  logic [31:0]  reg_rdata;
  logic [3:0]   comb_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [127:0] m_flags;
  logic [31:0]  m_mask [4];
  logic [3:0]   m_comb, m_combd;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_flag_combiner dut_i (
    .clk(clk), .rst_n(rst_n), .sys_evt(sys_evt), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata), .comb_out(comb_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    case (a[3:2])
      2'd0:    return m_flags[a[1:0]*32 +: 32];
      2'd3:    return m_mask[a[1:0]];
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step(input logic [123:0] ev, input bit we, input logic [3:0] a, input logic [31:0] d);
    logic [127:0] setv, clrv, hw;
    logic [3:0]   nc;
    setv = '0; clrv = '0;
    hw = {ev, m_comb & ~m_combd};
    for (int g = 0; g < 4; g++) nc[g] = |(m_flags[g*32 +: 32] & ~m_mask[g]);
    if (we) begin
      if (a[3:2] == 2'd1) setv[a[1:0]*32 +: 32] = d;
      if (a[3:2] == 2'd2) clrv[a[1:0]*32 +: 32] = d;
      if (a[3:2] == 2'd3) m_mask[a[1:0]] = d;
    end
    m_flags = (m_flags & ~clrv) | setv | hw;
    m_combd = m_comb;
    m_comb  = nc;
  endtask

  task automatic cyc(input logic [123:0] ev, input bit we, input logic [3:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    chk("R7 comb_out", {28'h0, comb_out}, {28'h0, m_comb});
    sys_evt = ev; reg_we = we; reg_addr = a; reg_wdata = d;
    #1;
    if (!we) chk(tag, reg_rdata, exp_rd(a));
    @(posedge clk);
    model_step(ev, we, a, d);
    #1;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] ed, input logic [3:0] ec, input string tag);
    @(negedge clk);
    chk(tag, {28'h0, comb_out}, {28'h0, ec});
    sys_evt = '0; reg_we = 1'b0; reg_addr = a; reg_wdata = '0;
    #1;
    chk(tag, reg_rdata, ed);
    @(posedge clk);
    model_step('0, 1'b0, a, '0);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [123:0] ev;
    logic [3:0]   a;
    logic [31:0]  d;
    bit           we;
    string        tag;
    void'($urandom(32'd1357));
    m_flags = '0; m_comb = '0; m_combd = '0;
    for (int g = 0; g < 4; g++) m_mask[g] = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    for (int i = 0; i < 16; i++)
      rd(4'(i), (i >= 12) ? 32'hFFFF_FFFF : 32'h0, 4'h0, "R1 R9 reset");

    ev = '0; ev[0] = 1'b1;
    cyc(ev, 1'b0, 4'd0, 32'h0, "R2");
    rd(4'd0, 32'h10, 4'h0, "R2 event latched");
    cyc('0, 1'b1, 4'd0, 32'hFFFF_FFFF, "R2");
    rd(4'd0, 32'h10, 4'h0, "R2 flag write ignored");

    cyc('0, 1'b1, 4'd5, 32'h5, "R3");
    rd(4'd1, 32'h5, 4'h0, "R3 set");
    rd(4'd5, 32'h0, 4'h0, "R3 set reads zero");

    cyc('0, 1'b1, 4'd9, 32'h1, "R4");
    rd(4'd1, 32'h4, 4'h0, "R4 clear");
    cyc('0, 1'b1, 4'd9, 32'h0, "R4");
    rd(4'd1, 32'h4, 4'h0, "R4 zero clear no effect");
    rd(4'd9, 32'h0, 4'h0, "R4 clear reads zero");

    cyc(ev, 1'b1, 4'd8, 32'h10, "R5");
    rd(4'd0, 32'h10, 4'h0, "R5 event beats clear");

    cyc('0, 1'b1, 4'd13, 32'hFFFF_FFFB, "R6");
    rd(4'd13, 32'hFFFF_FFFB, 4'h0, "R6 mask readback, R7 not yet");
    rd(4'd0, 32'h10, 4'h2, "R7 comb one cycle late");
    rd(4'd0, 32'h12, 4'h2, "R8 feedback flag set");
    cyc('0, 1'b1, 4'd8, 32'h2, "R8");
    rd(4'd0, 32'h10, 4'h2, "R8 no second feedback set");
    rd(4'd1, 32'h4, 4'h2, "R10 hold");

    for (int n = 0; n < 4000; n++) begin
      for (int w = 0; w < 4; w++)
        ev[w*31 +: 31] = 31'($urandom & $urandom & $urandom & $urandom);
      we = ($urandom % 10) < 3;
      a  = 4'($urandom);
      d  = ($urandom % 2) ? $urandom : ($urandom & $urandom & $urandom);
      if ($urandom % 4 == 0) ev = '0;
      if (we) tag = (a[3:2] == 2'd1) ? "R3 rand" : (a[3:2] == 2'd2) ? "R4 R5 rand" :
                    (a[3:2] == 2'd3) ? "R6 rand" : "R2 rand";
      else    tag = "R9 R10 rand read";
      cyc(ev, we, a, d, tag);
    end

    for (int i = 0; i < 16; i++) cyc('0, 1'b0, 4'(i), 32'h0, "R8 R10 final read");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule